// File: doc/BRIEF.md
# Program Memory Read Partition Guard

This block sits between a small CPU core and its program memory. It splits code space into a lower and an upper partition at a boundary that software cannot change once the chip is out of reset. It then decides, for each data read of code space (a table-lookup read), whether the issuing instruction may see the real memory contents. A read issued by an instruction in the upper partition that targets the lower partition returns 0x00 and raises a one-cycle violation pulse. Any other read returns the memory data unchanged.

Instruction fetch data is not filtered. Execution may move freely between partitions. The boundary is an 8-bit limit value placed in the upper byte of the 16-bit address, with a zero lower byte. The limit is captured from a configuration input while reset is asserted.

Top module: `read_partition_guard`

## Requirements
- R1: The boundary address is `{limit, 8'h00}`, where the limit is captured from `cfg_limit`. The lower partition is every address below the boundary. The upper partition is every address at or above it.
- R2: A table read whose `issue_pc` is in the upper partition and whose `tbl_addr` is in the lower partition returns `tbl_rdata == 8'h00` in the cycle after `tbl_rd` is sampled high.
- R3: A table read whose `issue_pc` is in the lower partition returns `mem_rdata` on `tbl_rdata` in the cycle after the request, whatever the target address.
- R4: A table read from the upper partition that targets the upper partition returns `mem_rdata` in the cycle after the request.
- R5: With a limit of 0x00, every table read returns `mem_rdata` and `tbl_violation` never rises.
- R6: `tbl_violation` is high for exactly the one cycle following a blocked read. It is low after any permitted read and in any cycle not following a read.
- R7: The limit is loaded only while `rst_n` is low. A change on `cfg_limit` after reset has no effect on which reads are blocked.
- R8: `fetch_data_o` equals `fetch_data_i` combinationally, for any limit and any address.
- R9: While `rst_n` is low and in the first cycle after reset, `tbl_violation` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; limit is captured while low |
| cfg_limit | input | LIMIT_W | Boundary page number, sampled only during reset |
| issue_pc | input | ADDR_W | Address of the instruction issuing the table read |
| tbl_addr | input | ADDR_W | Target address of the table read |
| tbl_rd | input | 1 | Table read strobe |
| mem_rdata | input | DATA_W | Program memory data, valid one cycle after the request |
| tbl_rdata | output | DATA_W | Filtered table read data (memory data or 0x00) |
| tbl_violation | output | 1 | One-cycle pulse when a read was replaced by 0x00 |
| fetch_data_i | input | DATA_W | Instruction fetch data from memory |
| fetch_data_o | output | DATA_W | Instruction fetch data to the core, unchanged |

## Verification
The assertions take it for granted that memory returns the data for a read exactly one cycle after the strobe. They also assume `issue_pc` and `tbl_addr` are only meaningful in the cycle `tbl_rd` is high. The bench supplies a registered memory model whose data is a nonzero function of the address, so a forced zero is always distinguishable from real data. The bench changes its inputs only on the falling clock edge. The sweep covers several limits, including 0x00 and 0xFF. For each limit it places the issuing address and the target on every side of the boundary and on the first and last byte of the pages that touch it.

// File: rtl/read_partition_guard.sv
module read_partition_guard #(
  parameter int ADDR_W  = 16,
  parameter int LIMIT_W = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LIMIT_W-1:0] cfg_limit,
  input  logic [ADDR_W-1:0]  issue_pc,
  input  logic [ADDR_W-1:0]  tbl_addr,
  input  logic               tbl_rd,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [DATA_W-1:0]  tbl_rdata,
  output logic               tbl_violation,
  input  logic [DATA_W-1:0]  fetch_data_i,
  output logic [DATA_W-1:0]  fetch_data_o
);
  localparam int PAGE_W = ADDR_W - LIMIT_W;

  logic [LIMIT_W-1:0] limit_q;
  logic [ADDR_W-1:0]  boundary;
  logic               pc_upper, tgt_lower, block_now, block_q;

  always_ff @(posedge clk)
    if (!rst_n) limit_q <= cfg_limit;

  assign boundary  = {limit_q, {PAGE_W{1'b0}}};
  assign pc_upper  = issue_pc >= boundary;
  assign tgt_lower = tbl_addr < boundary;
  assign block_now = tbl_rd && pc_upper && tgt_lower;

  always_ff @(posedge clk)
    if (!rst_n) block_q <= 1'b0;
    else        block_q <= block_now;

  assign tbl_rdata     = block_q ? '0 : mem_rdata;
  assign tbl_violation = block_q;
  assign fetch_data_o  = fetch_data_i;
endmodule

module read_partition_guard_chk #(
  parameter int ADDR_W  = 16,
  parameter int LIMIT_W = 8,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LIMIT_W-1:0] limit_q,
  input logic [ADDR_W-1:0]  issue_pc,
  input logic [ADDR_W-1:0]  tbl_addr,
  input logic               tbl_rd,
  input logic [DATA_W-1:0]  mem_rdata,
  input logic [DATA_W-1:0]  tbl_rdata,
  input logic               tbl_violation
);
  localparam int PAGE_W = ADDR_W - LIMIT_W;
  logic [ADDR_W-1:0] bnd;
  assign bnd = {limit_q, {PAGE_W{1'b0}}};

  // R2
  blocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd && issue_pc >= bnd && tbl_addr < bnd) |=> (tbl_rdata == '0 && tbl_violation));

  // R3
  lower_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd && issue_pc < bnd) |=> (tbl_rdata == mem_rdata && !tbl_violation));

  // R4
  upper_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd && tbl_addr >= bnd) |=> (tbl_rdata == mem_rdata && !tbl_violation));

  // R5
  open_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_q == '0) |=> !tbl_violation);

  // R6
  pulse_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_violation |-> $past(tbl_rd));

  // R7
  limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(limit_q));
endmodule

bind read_partition_guard read_partition_guard_chk #(
  .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .limit_q(limit_q), .issue_pc(issue_pc),
  .tbl_addr(tbl_addr), .tbl_rd(tbl_rd), .mem_rdata(mem_rdata),
  .tbl_rdata(tbl_rdata), .tbl_violation(tbl_violation)
);

// File: tb/tb_read_partition_guard.sv
module tb_read_partition_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_limit = 8'h00;
  logic [15:0] issue_pc = '0;
  logic [15:0] tbl_addr = '0;
  logic        tbl_rd = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  tbl_rdata;
  logic        tbl_violation;
  logic [7:0]  fetch_data_i = '0;
  logic [7:0]  fetch_data_o;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  read_partition_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_limit(cfg_limit), .issue_pc(issue_pc),
    .tbl_addr(tbl_addr), .tbl_rd(tbl_rd), .mem_rdata(mem_rdata),
    .tbl_rdata(tbl_rdata), .tbl_violation(tbl_violation),
    .fetch_data_i(fetch_data_i), .fetch_data_o(fetch_data_o)
  );

  function automatic logic [7:0] mem_val(logic [15:0] a);
    return (a[7:0] ^ a[15:8] ^ 8'h3C) | 8'h01;
  endfunction

  always_ff @(posedge clk) mem_rdata <= mem_val(tbl_addr);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [7:0] lim);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_limit = lim;
    repeat (3) @(negedge clk);
    chk("R9 reset violation", {15'd0, tbl_violation}, 16'd0);
    rst_n = 1'b1;
    cfg_limit = ~lim;  // R7: later change must be ignored
    @(negedge clk);
    chk("R9 first cycle violation", {15'd0, tbl_violation}, 16'd0);
  endtask

  task automatic do_read(logic [7:0] lim, logic [15:0] pc, logic [15:0] a);
    logic [15:0] bnd;
    logic blk;
    bnd = {lim, 8'h00};
    blk = (pc >= bnd) && (a < bnd);
    issue_pc = pc;
    tbl_addr = a;
    tbl_rd = 1'b1;
    @(negedge clk);
    tbl_rd = 1'b0;
    if (lim == 8'h00)
      chk("R5 open limit data", {8'h00, tbl_rdata}, {8'h00, mem_val(a)});
    else if (blk)
      chk("R2 blocked data R1 R7", {8'h00, tbl_rdata}, 16'h0000);
    else if (pc < bnd)
      chk("R3 lower reader data", {8'h00, tbl_rdata}, {8'h00, mem_val(a)});
    else
      chk("R4 upper to upper data", {8'h00, tbl_rdata}, {8'h00, mem_val(a)});
    chk("R6 violation after read", {15'd0, tbl_violation}, {15'd0, blk});
    @(negedge clk);
    chk("R6 violation idle", {15'd0, tbl_violation}, 16'd0);
  endtask

  initial begin
    logic [7:0] lims [5];
    lims = '{8'h00, 8'h01, 8'h40, 8'h7F, 8'hFF};
    for (int k = 0; k < 5; k++) begin
      do_reset(lims[k]);
      for (int p = 0; p < 16; p++)
        for (int t = 0; t < 32; t++)
          do_read(lims[k], {8'(p * 17), 8'h80}, {8'(t[4:1] * 17), t[0] ? 8'hFF : 8'h00});
      for (int e = 0; e < 16; e++)
        do_read(lims[k],
                {e[3] ? lims[k] : 8'(lims[k] - 8'h01), e[2] ? 8'hFF : 8'h00},
                {e[1] ? lims[k] : 8'(lims[k] - 8'h01), e[0] ? 8'hFF : 8'h00});
      for (int f = 0; f < 8; f++) begin
        @(negedge clk);
        fetch_data_i = 8'(f * 37 + k);
        #1;
        chk("R8 fetch passthrough", {8'h00, fetch_data_o}, {8'h00, 8'(f * 37 + k)});
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule